// File: doc/BRIEF.md
# Hardware Channel Enable Table

This block holds the setup for a bank of bus channels in a serial register bridge and picks which hardware source may start the next transaction. Of the channels, the lowest ones are kept for software-initiated access. Each of the others is a hardware-triggered source with a 32-bit setup word and an enable bit. A simple register port lets software write and read back the setup words, the enable words and two priority words.

Each hardware source raises a request line. The request only counts if the channel is enabled. Among the requests that count, the block grants exactly one channel through a one-hot grant vector and holds it until the consumer pulses a done input. Channels marked in the priority words are served before unmarked ones. Inside a class the lowest channel number wins. A setup write that targets the channel now holding the grant is parked. It is copied into the table on the release, so the transaction in flight sees a stable setup word.

Top module: `chan_table`

## Requirements
- R1: After reset every enable bit, priority bit, setup word and the read data are zero, and no grant is asserted.
- R2: The setup word of channel n (2 to 49) sits at byte address 0x44 + 4·(n−2). A write stores all 32 bits. A read of that address returns them on regRdData in the cycle after the read strobe.
- R3: The enable word at address 0x40 holds bit n for channels n below 32. Bits 0 and 1 always read zero and ignore writes.
- R4: The enable word at address 0x20C holds channels 32 to 49 at bit n−32. Bits 18 to 31 read zero.
- R5: A request from a disabled channel, or on request lines 0 or 1, is never granted. While no eligible request exists the grant vector stays zero.
- R6: When several eligible requests share a priority class, the lowest channel number receives the grant. The grant appears one cycle after the request is seen, and at most one grant bit is ever set.
- R7: The priority words live at 0x08 (channels 0–31, bit n) and 0x0C (channels 32–49, bit n−32). A set bit puts that channel ahead of all channels whose bit is clear. Bits 0 and 1 read zero. With both words at zero, every channel is in the same default class.
- R8: A grant stays unchanged, even while lower channels request, until grantDone is high at a clock edge. The grant vector is zero after that edge, and a new grant can follow one cycle later. A grantDone while no grant is held has no effect.
- R9: A setup write to the channel that holds the grant does not change that channel's readable word until the release edge, where it is applied. A second such write before the release replaces the parked value. Writes to other channels take effect at once.
- R10: Reads of any address not listed in R2, R3, R4 and R7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Byte address of the register access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, registered, valid the cycle after regRdEn |
| reqIn | input | 50 | Per-channel hardware request |
| grantDone | input | 1 | Pulse that releases the current grant |
| grantOut | output | 50 | One-hot grant, zero when idle |

## Verification
Register writes land at the clock edge that samples the write strobe. Read data is due on the edge after the read strobe. A grant is due one edge after an eligible request, and its clearing is due on the edge that samples grantDone. The bench drives inputs on the falling edge. It checks grant vectors at the next falling edge, once the relevant rising edge has passed. Expected read values are queued by the read task, and a monitor pops and compares them shortly after the rising edge that captures them. Parked setup writes are checked by reading the word both before and after the release edge.

// File: rtl/chan_table_pkg.sv
package chan_table_pkg;

  localparam int REG_W = 32;
  localparam int IDX_W = 6;

  localparam int OFS_PRI_LO = 'h008;
  localparam int OFS_PRI_HI = 'h00C;
  localparam int OFS_EN_LO  = 'h040;
  localparam int OFS_CFG    = 'h044;
  localparam int OFS_EN_HI  = 'h20C;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PRI_LO,
    RD_PRI_HI,
    RD_EN_LO,
    RD_EN_HI,
    RD_CFG
  } rdsel_t;

  typedef struct packed {
    logic             enLoWr;
    logic             enHiWr;
    logic             priLoWr;
    logic             priHiWr;
    logic             cfgWr;
    logic             cfgDefer;
    logic             pendApply;
    logic [IDX_W-1:0] cfgIdx;
    logic             rdEn;
    rdsel_t           rdSel;
  } strobe_t;

endpackage

// File: rtl/chan_pick.sv
module chan_pick #(
  parameter int W = 50
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] oneHot
);
  always_comb begin
    oneHot = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        oneHot    = '0;
        oneHot[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/chan_ctrl.sv
module chan_ctrl
  import chan_table_pkg::*;
#(
  parameter int NUM_CH = 50,
  parameter int SW_CH  = 2,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NUM_CH-1:0] reqIn,
  input  logic              grantDone,
  input  logic [NUM_CH-1:0] enMask,
  input  logic [NUM_CH-1:0] hiPri,
  output strobe_t           strb,
  output logic [NUM_CH-1:0] grantOut
);
  localparam int HW_CH   = NUM_CH - SW_CH;
  localparam int CFG_END = OFS_CFG + 4 * HW_CH;

  logic              cfgHit;
  logic [ADDR_W-1:0] cfgOfs;
  logic [IDX_W-1:0]  cfgIdx;
  logic [IDX_W-1:0]  grantIdx;
  logic              grantActive;
  logic [NUM_CH-1:0] eligible;
  logic [NUM_CH-1:0] hiEligible;
  logic [NUM_CH-1:0] pickAll;
  logic [NUM_CH-1:0] pickHi;
  logic [NUM_CH-1:0] nextGrant;
  logic              isPriLo, isPriHi, isEnLo, isEnHi;

  // address decode
  assign isPriLo = (int'(regAddr) == OFS_PRI_LO);
  assign isPriHi = (int'(regAddr) == OFS_PRI_HI);
  assign isEnLo  = (int'(regAddr) == OFS_EN_LO);
  assign isEnHi  = (int'(regAddr) == OFS_EN_HI);
  assign cfgHit  = (int'(regAddr) >= OFS_CFG) && (int'(regAddr) < CFG_END) &&
                   (regAddr[1:0] == 2'b00);
  assign cfgOfs  = regAddr - ADDR_W'(OFS_CFG);
  assign cfgIdx  = cfgOfs[IDX_W+1:2] + IDX_W'(SW_CH);

  // one-hot to index of current grant
  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (grantOut[i]) grantIdx = IDX_W'(i);
    end
  end
  assign grantActive = |grantOut;

  // strobes towards the datapath
  always_comb begin
    strb          = '0;
    strb.cfgIdx   = cfgIdx;
    strb.enLoWr   = regWrEn && isEnLo;
    strb.enHiWr   = regWrEn && isEnHi;
    strb.priLoWr  = regWrEn && isPriLo;
    strb.priHiWr  = regWrEn && isPriHi;
    strb.cfgDefer = regWrEn && cfgHit && grantActive && !grantDone &&
                    (cfgIdx == grantIdx);
    strb.cfgWr    = regWrEn && cfgHit && !strb.cfgDefer;
    strb.pendApply = grantActive && grantDone;
    strb.rdEn     = regRdEn;
    if (isPriLo)      strb.rdSel = RD_PRI_LO;
    else if (isPriHi) strb.rdSel = RD_PRI_HI;
    else if (isEnLo)  strb.rdSel = RD_EN_LO;
    else if (isEnHi)  strb.rdSel = RD_EN_HI;
    else if (cfgHit)  strb.rdSel = RD_CFG;
    else              strb.rdSel = RD_NONE;
  end

  // arbitration: high class first, lowest index inside a class
  assign eligible   = reqIn & enMask;
  assign hiEligible = eligible & hiPri;

  chan_pick #(.W(NUM_CH)) i_pickAll (.vec(eligible),   .oneHot(pickAll));
  chan_pick #(.W(NUM_CH)) i_pickHi  (.vec(hiEligible), .oneHot(pickHi));

  assign nextGrant = (|hiEligible) ? pickHi : pickAll;

  always_ff @(posedge clk) begin
    if (rst) begin
      grantOut <= '0;
    end else if (grantActive) begin
      if (grantDone) grantOut <= '0;
    end else begin
      grantOut <= nextGrant;
    end
  end
endmodule

// File: rtl/chan_dpath.sv
module chan_dpath
  import chan_table_pkg::*;
#(
  parameter int NUM_CH = 50,
  parameter int SW_CH  = 2,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [REG_W-1:0]  wrData,
  output logic [NUM_CH-1:0] enMask,
  output logic [NUM_CH-1:0] hiPri,
  output logic [REG_W-1:0]  rdData
);
  localparam int HW_CH = NUM_CH - SW_CH;

  logic [CFG_W-1:0] cfgMem [HW_CH];
  logic             pendValid;
  logic [IDX_W-1:0] pendIdx;
  logic [CFG_W-1:0] pendData;
  logic [63:0]      enPad;
  logic [63:0]      priPad;
  logic [IDX_W-1:0] rdHwIdx;

  // enable and priority bits: software channels stay zero
  always_ff @(posedge clk) begin
    if (rst) begin
      enMask <= '0;
      hiPri  <= '0;
    end else begin
      for (int i = SW_CH; i < NUM_CH; i++) begin
        if (i < 32) begin
          if (strb.enLoWr)  enMask[i] <= wrData[i % 32];
          if (strb.priLoWr) hiPri[i]  <= wrData[i % 32];
        end else begin
          if (strb.enHiWr)  enMask[i] <= wrData[i % 32];
          if (strb.priHiWr) hiPri[i]  <= wrData[i % 32];
        end
      end
    end
  end

  // parked write for the granted channel
  always_ff @(posedge clk) begin
    if (rst) begin
      pendValid <= 1'b0;
      pendIdx   <= '0;
      pendData  <= '0;
    end else if (strb.cfgDefer) begin
      pendValid <= 1'b1;
      pendIdx   <= strb.cfgIdx;
      pendData  <= wrData[CFG_W-1:0];
    end else if (strb.pendApply) begin
      pendValid <= 1'b0;
    end
  end

  // one setup register per hardware channel
  for (genvar g = 0; g < HW_CH; g++) begin : g_cfg
    localparam logic [IDX_W-1:0] CH = IDX_W'(g + SW_CH);
    always_ff @(posedge clk) begin
      if (rst) begin
        cfgMem[g] <= '0;
      end else if (strb.cfgWr && strb.cfgIdx == CH) begin
        cfgMem[g] <= wrData[CFG_W-1:0];
      end else if (strb.pendApply && pendValid && pendIdx == CH) begin
        cfgMem[g] <= pendData;
      end
    end
  end

  // registered read mux
  assign enPad   = 64'(enMask);
  assign priPad  = 64'(hiPri);
  assign rdHwIdx = strb.cfgIdx - IDX_W'(SW_CH);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strb.rdEn) begin
      case (strb.rdSel)
        RD_PRI_LO: rdData <= priPad[31:0];
        RD_PRI_HI: rdData <= priPad[63:32];
        RD_EN_LO:  rdData <= enPad[31:0];
        RD_EN_HI:  rdData <= enPad[63:32];
        RD_CFG:    rdData <= REG_W'(cfgMem[rdHwIdx]);
        default:   rdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/chan_table.sv
module chan_table
  import chan_table_pkg::*;
#(
  parameter int NUM_CH = 50,
  parameter int SW_CH  = 2,
  parameter int ADDR_W = 12,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [NUM_CH-1:0] reqIn,
  input  logic              grantDone,
  output logic [NUM_CH-1:0] grantOut
);
  strobe_t           strb;
  logic [NUM_CH-1:0] enMask;
  logic [NUM_CH-1:0] hiPri;

  chan_ctrl #(.NUM_CH(NUM_CH), .SW_CH(SW_CH), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .reqIn(reqIn), .grantDone(grantDone),
    .enMask(enMask), .hiPri(hiPri), .strb(strb), .grantOut(grantOut)
  );

  chan_dpath #(.NUM_CH(NUM_CH), .SW_CH(SW_CH), .CFG_W(CFG_W)) i_dpath (
    .clk(clk), .rst(rst), .strb(strb), .wrData(regWrData),
    .enMask(enMask), .hiPri(hiPri), .rdData(regRdData)
  );
endmodule

// File: rtl/chan_table_chk.sv
module chan_table_chk #(
  parameter int NUM_CH = 50,
  parameter int SW_CH  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] reqIn,
  input logic              grantDone,
  input logic [NUM_CH-1:0] grantOut,
  input logic [NUM_CH-1:0] enMask
);
  assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grantOut));

  assert_sw_never_granted_R5: assert property (@(posedge clk) disable iff (rst)
    grantOut[SW_CH-1:0] == '0);

  assert_sw_enable_zero_R3: assert property (@(posedge clk) disable iff (rst)
    enMask[SW_CH-1:0] == '0);

  assert_grant_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ((|grantOut) && !grantDone) |=> $stable(grantOut));

  assert_grant_release_R8: assert property (@(posedge clk) disable iff (rst)
    ((|grantOut) && grantDone) |=> (grantOut == '0));

  assert_grant_eligible_R5: assert property (@(posedge clk) disable iff (rst)
    ((|grantOut) && !(|$past(grantOut))) |->
      ((grantOut & $past(reqIn) & $past(enMask)) == grantOut));
endmodule

bind chan_table chan_table_chk #(.NUM_CH(NUM_CH), .SW_CH(SW_CH)) i_chk (
  .clk(clk), .rst(rst), .reqIn(reqIn), .grantDone(grantDone),
  .grantOut(grantOut), .enMask(enMask)
);

// File: tb/test_chan_table.sv
module test_chan_table;
  localparam int NCH = 50;

  logic           clk = 1'b0;
  logic           rst;
  logic           regWrEn = 1'b0;
  logic           regRdEn = 1'b0;
  logic [11:0]    regAddr = '0;
  logic [31:0]    regWrData = '0;
  logic [31:0]    regRdData;
  logic [NCH-1:0] reqIn = '0;
  logic           grantDone = 1'b0;
  logic [NCH-1:0] grantOut;

  int tests = 0;
  int fails = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  chan_table i_chan_table (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .reqIn(reqIn), .grantDone(grantDone), .grantOut(grantOut)
  );

  function automatic logic [11:0] cfgAddr(int ch);
    return 12'(32'h44 + 4 * (ch - 2));
  endfunction

  function automatic logic [NCH-1:0] bitOf(int ch);
    logic [NCH-1:0] v = '0;
    v[ch] = 1'b1;
    return v;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // driver: pushes the expected value, monitor compares it
  task automatic rdReg(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic chkGrant(input logic [NCH-1:0] e, input string tag);
    tests++;
    if (grantOut !== e) begin
      fails++;
      $display("FAIL %s grant actual=%h expected=%h", tag, grantOut, e);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (regRdEn) begin
        #2;
        tests++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL unexpected read actual=%h expected=none", regRdData);
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (regRdData !== e) begin
            fails++;
            $display("FAIL %s read actual=%h expected=%h", t, regRdData, e);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chkGrant('0, "R1");
    rdReg(12'h040, 32'h0, "R1 enLo");
    rdReg(12'h20C, 32'h0, "R1 enHi");
    rdReg(12'h008, 32'h0, "R1 priLo");
    rdReg(cfgAddr(2), 32'h0, "R1 cfg2");
    rdReg(cfgAddr(49), 32'h0, "R1 cfg49");

    // R2 setup words
    wrReg(cfgAddr(2), 32'hA5A5_0102);
    wrReg(cfgAddr(49), 32'h1234_5678);
    wrReg(cfgAddr(17), 32'hDEAD_BEEF);
    rdReg(cfgAddr(2), 32'hA5A5_0102, "R2 cfg2");
    rdReg(cfgAddr(49), 32'h1234_5678, "R2 cfg49");
    rdReg(cfgAddr(17), 32'hDEAD_BEEF, "R2 cfg17");

    // R3, R4 enable words
    wrReg(12'h040, 32'hFFFF_FFFF);
    rdReg(12'h040, 32'hFFFF_FFFC, "R3 enLo all");
    wrReg(12'h20C, 32'hFFFF_FFFF);
    rdReg(12'h20C, 32'h0003_FFFF, "R4 enHi all");
    wrReg(12'h040, 32'h0000_0F03);
    rdReg(12'h040, 32'h0000_0F00, "R3 enLo sw bits");
    wrReg(12'h20C, 32'h0000_0002);
    rdReg(12'h20C, 32'h0000_0002, "R4 enHi ch33");

    // R10 unmapped
    rdReg(12'h000, 32'h0, "R10 addr0");
    rdReg(12'h104, 32'h0, "R10 past cfg");
    rdReg(12'h200, 32'h0, "R10 addr200");

    // R5 disabled and software request lines
    step();
    reqIn = bitOf(0) | bitOf(1) | bitOf(5) | bitOf(40);
    step(); step();
    chkGrant('0, "R5 disabled");

    // R6 lowest wins
    reqIn = bitOf(9) | bitOf(11) | bitOf(33);
    step();
    chkGrant(bitOf(9), "R6 lowest");
    grantDone = 1'b1;
    reqIn = bitOf(11) | bitOf(33);
    step();
    chkGrant('0, "R8 release");
    grantDone = 1'b0;
    step();
    chkGrant(bitOf(11), "R6 next lowest");

    // R8 hold against lower request
    reqIn = reqIn | bitOf(8);
    step(); step(); step();
    chkGrant(bitOf(11), "R8 hold");
    grantDone = 1'b1;
    reqIn = '0;
    step();
    chkGrant('0, "R8 release2");
    grantDone = 1'b1;
    step();
    grantDone = 1'b0;
    step();
    chkGrant('0, "R8 idle done");

    // R7 priority class
    wrReg(12'h00C, 32'h0000_0002);
    rdReg(12'h00C, 32'h0000_0002, "R7 priHi");
    wrReg(12'h008, 32'hFFFF_FFFF);
    rdReg(12'h008, 32'hFFFF_FFFC, "R7 priLo sw bits");
    wrReg(12'h008, 32'h0);
    reqIn = bitOf(8) | bitOf(33);
    step();
    chkGrant(bitOf(33), "R7 high class");
    wrReg(12'h00C, 32'h0);
    chkGrant(bitOf(33), "R8 hold during write");
    grantDone = 1'b1;
    step();
    chkGrant('0, "R7 release");
    grantDone = 1'b0;
    step();
    chkGrant(bitOf(8), "R7 default class");
    reqIn = '0;

    // R9 parked write to granted channel 8
    wrReg(cfgAddr(8), 32'h0000_00D1);
    rdReg(cfgAddr(8), 32'h0, "R9 parked old");
    wrReg(cfgAddr(8), 32'h0000_00E2);
    rdReg(cfgAddr(8), 32'h0, "R9 parked replace");
    wrReg(cfgAddr(9), 32'h0000_00F3);
    rdReg(cfgAddr(9), 32'h0000_00F3, "R9 other direct");
    chkGrant(bitOf(8), "R9 grant held");
    grantDone = 1'b1;
    step();
    grantDone = 1'b0;
    chkGrant('0, "R9 release");
    rdReg(cfgAddr(8), 32'h0000_00E2, "R9 applied");

    step(); step();
    tests++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R2 reads left actual=%0d expected=0", expQ.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule